// File: doc/BRIEF.md
# Hidden Configuration Register Bank Behind a Task-File Port

This block sits on the device side of a byte/word task-file I/O port. In normal operation every access goes through to the ordinary task-file registers, and the block is invisible. Five configuration registers are hidden behind the port: read-cycle timing, write-cycle timing, control, strap and miscellaneous. They open only after a fixed pattern of ordinary I/O cycles: two 16-bit reads of offset 1 in a row, then a byte write of the open key to offset 2. While the bank is open, accesses to the configuration offsets reach the hidden registers instead of the task-file. A byte write of the close key to offset 2 shuts the bank again.

The configuration values are driven out to the drive-bus timing logic. The effective read and write timings follow the bus-clock strap defaults until software sets the override bit in the control register. A separate probe lets software read the bus-clock strap: it writes the arm byte to offset 5 and then does a 16-bit read of the same offset.

Top module: `cfgtrap_bank`

## Requirements
- R1: After reset the bank is closed, all five configuration registers hold 0x00, the override bit is clear, and both effective timings equal the strap default (0x6B when `strap_clk`=0, 0x58 when `strap_clk`=1).
- R2: Two 16-bit reads of offset 1 with no access between them, followed by a byte write of 0x03 to offset 2, open the bank from the next cycle. That key write is consumed and does not raise `tf_req`.
- R3: While the bank is closed, reads of offset 1 are forwarded (`tf_req`=1) and return `tf_rdata` unchanged, so the opening reads have no visible side effect.
- R4: Any other access after the first opening read and before the key write aborts the sequence, and that includes an 8-bit read of offset 1. A key write that follows an abort is forwarded and leaves the bank closed. A further 16-bit read of offset 1 after two of them keeps the sequence armed.
- R5: A key write without the two preceding reads is forwarded to the task-file, and the bank stays closed.
- R6: While the bank is open, a write to offset 0, 1, 3, 5 or 6 stores the low data byte in, respectively, read timing, write timing, control, strap or miscellaneous. A read of one of those offsets returns the register value zero-extended. Neither kind of access raises `tf_req`.
- R7: While the bank is open, accesses to offsets 2, 4 and 7 are forwarded (`tf_req`=1), except the close key. Reads there return `tf_rdata`, and a byte of 0x03 to offset 2 is an ordinary forwarded write.
- R8: A byte write of 0x83 to offset 2 while the bank is open is consumed and closes the bank from the next cycle. Writes made while the bank is closed change no configuration register and are forwarded.
- R9: A write whose low byte is 0xFF to offset 5 arms the strap probe, whether the bank is open or closed. If the very next access is a 16-bit read of offset 5, it returns `strap_clk` in bit 0 with all other bits zero and is not forwarded. Any other access disarms the probe.
- R10: Bit 2 of the control register is the override bit. When it is set, the effective timings equal the programmed read and write timing registers. When it is clear, they equal the strap default of R1.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_valid | input | 1 | One-cycle access strobe |
| io_write | input | 1 | 1 = write, 0 = read |
| io_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| io_addr | input | 3 | Port offset |
| io_wdata | input | 16 | Write data (low byte used by the bank) |
| io_rdata | output | 16 | Read data returned for the current access |
| tf_rdata | input | 16 | Read data from the normal task-file registers |
| tf_req | output | 1 | Current access is routed to the task-file |
| strap_clk | input | 1 | Bus-clock strap pin |
| unlocked | output | 1 | Bank is open |
| cfg_rd_tim | output | 8 | Programmed read timing |
| cfg_wr_tim | output | 8 | Programmed write timing |
| cfg_ctrl | output | 8 | Control register |
| cfg_strap | output | 8 | Strap register |
| cfg_misc | output | 8 | Miscellaneous register |
| tim_override | output | 1 | Programmed timings in effect |
| eff_rd_tim | output | 8 | Effective read timing |
| eff_wr_tim | output | 8 | Effective write timing |

## Verification
The opening pattern is driven in its correct form and in near-miss forms. The near misses are a bare key write, a foreign read or write between the reads, and an 8-bit read of offset 1. Together these separate a detector that really tracks consecutive accesses from one that only counts reads or only looks at the key. Each configuration offset is written and read back while the bank is open and then again after it is closed, which shows that routing depends on the lock state. The strap probe is run with the bank open and with it closed, and followed by an unarmed read, to show that the probe lasts for exactly one access. The override bit is toggled under both strap values to show which timing source is selected.

// File: rtl/cfgtrap_pkg.sv
`timescale 1ns/1ps
package cfgtrap_pkg;

  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_ONE  = 2'd1,
    TS_TWO  = 2'd2,
    TS_OPEN = 2'd3
  } trap_st_e;

  // offsets whose meaning the host software depends on
  localparam int OFF_PROBE_RD = 1;
  localparam int OFF_KEY      = 2;
  localparam int OFF_STRAP    = 5;

  // bank slot order: read timing, write timing, control, strap, misc
  localparam int NSLOT      = 5;
  localparam int SLOT_RDTIM = 0;
  localparam int SLOT_WRTIM = 1;
  localparam int SLOT_CTRL  = 2;
  localparam int SLOT_STRAP = 3;
  localparam int SLOT_MISC  = 4;

  function automatic int slot_off(input int slot);
    case (slot)
      SLOT_RDTIM: slot_off = 0;
      SLOT_WRTIM: slot_off = 1;
      SLOT_CTRL:  slot_off = 3;
      SLOT_STRAP: slot_off = 5;
      default:    slot_off = 6;
    endcase
  endfunction

endpackage

// File: rtl/cfgtrap_seq.sv
`timescale 1ns/1ps
module cfgtrap_seq
  import cfgtrap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic acc_valid,
  input  logic probe_rd,
  input  logic open_wr,
  input  logic close_wr,
  output logic is_open,
  output logic open_take,
  output logic close_take
);

  trap_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      TS_IDLE: if (probe_rd) st_d = TS_ONE;
      TS_ONE: begin
        if (probe_rd)       st_d = TS_TWO;
        else if (acc_valid) st_d = TS_IDLE;
      end
      TS_TWO: begin
        if (open_wr)        st_d = TS_OPEN;
        else if (probe_rd)  st_d = TS_TWO;
        else if (acc_valid) st_d = TS_IDLE;
      end
      TS_OPEN: if (close_wr) st_d = TS_IDLE;
      default: st_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= TS_IDLE;
    else        st_q <= st_d;
  end

  assign is_open    = (st_q == TS_OPEN);
  assign open_take  = (st_q == TS_TWO) && open_wr;
  assign close_take = (st_q == TS_OPEN) && close_wr;

endmodule

// File: rtl/cfgtrap_regs.sv
`timescale 1ns/1ps
module cfgtrap_regs
  import cfgtrap_pkg::*;
#(
  parameter int AW = 3,
  parameter int RW = 8,
  parameter logic [RW-1:0] TIM_DFLT0 = 8'h6B,
  parameter logic [RW-1:0] TIM_DFLT1 = 8'h58,
  parameter int OVR_BIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [RW-1:0] cfg_wbyte,
  input  logic          arm_set,
  input  logic          arm_clr,
  input  logic          strap_clk,
  output logic [RW-1:0] rd_val,
  output logic          strap_armed,
  output logic [RW-1:0] rd_tim,
  output logic [RW-1:0] wr_tim,
  output logic [RW-1:0] ctrl,
  output logic [RW-1:0] strap,
  output logic [RW-1:0] misc,
  output logic          override,
  output logic [RW-1:0] eff_rd,
  output logic [RW-1:0] eff_wr
);

  logic [RW-1:0] slot_q [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic          hit;
    logic [RW-1:0] q_r;
    assign hit = cfg_we && (cfg_addr == AW'(slot_off(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q_r <= '0;
      else if (hit) q_r <= cfg_wbyte;
    end
    assign slot_q[g] = q_r;
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (cfg_addr == AW'(slot_off(i))) rd_val = slot_q[i];
    end
  end

  logic arm_d, arm_q;
  always_comb begin
    arm_d = arm_q;
    if (arm_set)      arm_d = 1'b1;
    else if (arm_clr) arm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm_d;
  end

  assign strap_armed = arm_q;

  logic [RW-1:0] dflt;
  assign dflt     = strap_clk ? TIM_DFLT1 : TIM_DFLT0;
  assign rd_tim   = slot_q[SLOT_RDTIM];
  assign wr_tim   = slot_q[SLOT_WRTIM];
  assign ctrl     = slot_q[SLOT_CTRL];
  assign strap    = slot_q[SLOT_STRAP];
  assign misc     = slot_q[SLOT_MISC];
  assign override = ctrl[OVR_BIT];
  assign eff_rd   = override ? rd_tim : dflt;
  assign eff_wr   = override ? wr_tim : dflt;

endmodule

// File: rtl/cfgtrap_rdmux.sv
`timescale 1ns/1ps
module cfgtrap_rdmux #(
  parameter int DW = 16,
  parameter int RW = 8
) (
  input  logic          strap_rd,
  input  logic          cfg_rd,
  input  logic [RW-1:0] cfg_val,
  input  logic          strap_clk,
  input  logic [DW-1:0] tf_rdata,
  output logic [DW-1:0] rdata
);

  localparam int PAD_W = DW - RW;

  always_comb begin
    if (strap_rd)    rdata = {{(DW-1){1'b0}}, strap_clk};
    else if (cfg_rd) rdata = {{PAD_W{1'b0}}, cfg_val};
    else             rdata = tf_rdata;
  end

endmodule

// File: rtl/cfgtrap_bank.sv
`timescale 1ns/1ps
module cfgtrap_bank
  import cfgtrap_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 16,
  parameter int RW = 8,
  parameter logic [RW-1:0] KEY_OPEN  = 8'h03,
  parameter logic [RW-1:0] KEY_CLOSE = 8'h83,
  parameter logic [RW-1:0] STRAP_ARM = 8'hFF,
  parameter logic [RW-1:0] TIM_DFLT0 = 8'h6B,
  parameter logic [RW-1:0] TIM_DFLT1 = 8'h58,
  parameter int OVR_BIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_valid,
  input  logic          io_write,
  input  logic          io_wide,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  input  logic [DW-1:0] tf_rdata,
  output logic          tf_req,
  input  logic          strap_clk,
  output logic          unlocked,
  output logic [RW-1:0] cfg_rd_tim,
  output logic [RW-1:0] cfg_wr_tim,
  output logic [RW-1:0] cfg_ctrl,
  output logic [RW-1:0] cfg_strap,
  output logic [RW-1:0] cfg_misc,
  output logic          tim_override,
  output logic [RW-1:0] eff_rd_tim,
  output logic [RW-1:0] eff_wr_tim
);

  logic [RW-1:0] wbyte;
  logic probe_rd, key_open_wr, key_close_wr;
  logic open_take, close_take;
  logic addr_cfg, cfg_acc, cfg_we, cfg_rd;
  logic strap_armed, strap_rd, arm_set, arm_clr;
  logic [RW-1:0] cfg_val;

  assign wbyte        = io_wdata[RW-1:0];
  assign probe_rd     = io_valid && !io_write && io_wide && (io_addr == AW'(OFF_PROBE_RD));
  assign key_open_wr  = io_valid && io_write && !io_wide && (io_addr == AW'(OFF_KEY)) && (wbyte == KEY_OPEN);
  assign key_close_wr = io_valid && io_write && !io_wide && (io_addr == AW'(OFF_KEY)) && (wbyte == KEY_CLOSE);

  always_comb begin
    addr_cfg = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (io_addr == AW'(slot_off(i))) addr_cfg = 1'b1;
    end
  end

  assign cfg_acc  = unlocked && io_valid && addr_cfg;
  assign cfg_we   = cfg_acc && io_write;
  assign cfg_rd   = cfg_acc && !io_write;
  assign strap_rd = strap_armed && io_valid && !io_write && io_wide && (io_addr == AW'(OFF_STRAP));
  assign arm_set  = io_valid && io_write && (io_addr == AW'(OFF_STRAP)) && (wbyte == STRAP_ARM);
  assign arm_clr  = io_valid && !arm_set;
  assign tf_req   = io_valid && !cfg_acc && !strap_rd && !open_take && !close_take;

  cfgtrap_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (io_valid),
    .probe_rd   (probe_rd),
    .open_wr    (key_open_wr),
    .close_wr   (key_close_wr),
    .is_open    (unlocked),
    .open_take  (open_take),
    .close_take (close_take)
  );

  cfgtrap_regs #(
    .AW(AW), .RW(RW), .TIM_DFLT0(TIM_DFLT0), .TIM_DFLT1(TIM_DFLT1), .OVR_BIT(OVR_BIT)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (io_addr),
    .cfg_wbyte   (wbyte),
    .arm_set     (arm_set),
    .arm_clr     (arm_clr),
    .strap_clk   (strap_clk),
    .rd_val      (cfg_val),
    .strap_armed (strap_armed),
    .rd_tim      (cfg_rd_tim),
    .wr_tim      (cfg_wr_tim),
    .ctrl        (cfg_ctrl),
    .strap       (cfg_strap),
    .misc        (cfg_misc),
    .override    (tim_override),
    .eff_rd      (eff_rd_tim),
    .eff_wr      (eff_wr_tim)
  );

  cfgtrap_rdmux #(.DW(DW), .RW(RW)) u_rdmux (
    .strap_rd  (strap_rd),
    .cfg_rd    (cfg_rd),
    .cfg_val   (cfg_val),
    .strap_clk (strap_clk),
    .tf_rdata  (tf_rdata),
    .rdata     (io_rdata)
  );

endmodule

// File: rtl/cfgtrap_bank_chk.sv
`timescale 1ns/1ps
module cfgtrap_bank_chk #(
  parameter int AW = 3,
  parameter int DW = 16,
  parameter int RW = 8,
  parameter logic [RW-1:0] KEY_OPEN  = 8'h03,
  parameter logic [RW-1:0] KEY_CLOSE = 8'h83,
  parameter logic [RW-1:0] TIM_DFLT0 = 8'h6B,
  parameter logic [RW-1:0] TIM_DFLT1 = 8'h58
) (
  input logic          clk,
  input logic          rst_n,
  input logic          io_valid,
  input logic          io_write,
  input logic          io_wide,
  input logic [AW-1:0] io_addr,
  input logic [DW-1:0] io_wdata,
  input logic [DW-1:0] io_rdata,
  input logic [DW-1:0] tf_rdata,
  input logic          tf_req,
  input logic          strap_clk,
  input logic          unlocked,
  input logic [RW-1:0] cfg_rd_tim,
  input logic [RW-1:0] cfg_wr_tim,
  input logic [RW-1:0] cfg_ctrl,
  input logic [RW-1:0] cfg_misc,
  input logic          tim_override,
  input logic [RW-1:0] eff_rd_tim
);

  p_open_by_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(io_valid && io_write && !io_wide &&
                              io_addr == AW'(2) && io_wdata[RW-1:0] == KEY_OPEN));

  p_probe_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && io_valid && !io_write && io_addr == AW'(1)) |-> (tf_req && io_rdata == tf_rdata));

  p_cfg_local_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && io_valid && io_write && io_addr == AW'(0)) |-> !tf_req);

  p_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && io_valid && io_write && !io_wide && io_addr == AW'(2) &&
     io_wdata[RW-1:0] == KEY_CLOSE) |=> !unlocked);

  p_locked_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !unlocked) |=> ($stable(cfg_rd_tim) && $stable(cfg_wr_tim) &&
                                 $stable(cfg_ctrl) && $stable(cfg_misc)));

  p_dflt_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tim_override |-> (eff_rd_tim == (strap_clk ? TIM_DFLT1 : TIM_DFLT0)));

endmodule

bind cfgtrap_bank cfgtrap_bank_chk #(
  .AW(AW), .DW(DW), .RW(RW), .KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE),
  .TIM_DFLT0(TIM_DFLT0), .TIM_DFLT1(TIM_DFLT1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
  .io_wide(io_wide), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
  .tf_rdata(tf_rdata), .tf_req(tf_req), .strap_clk(strap_clk), .unlocked(unlocked),
  .cfg_rd_tim(cfg_rd_tim), .cfg_wr_tim(cfg_wr_tim), .cfg_ctrl(cfg_ctrl),
  .cfg_misc(cfg_misc), .tim_override(tim_override), .eff_rd_tim(eff_rd_tim)
);

// File: tb/tb_cfgtrap_bank.sv
`timescale 1ns/1ps
module tb_cfgtrap_bank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_valid, io_write, io_wide;
  logic [2:0]  io_addr;
  logic [15:0] io_wdata, io_rdata, tf_rdata;
  logic        tf_req, strap_clk, unlocked, tim_override;
  logic [7:0]  cfg_rd_tim, cfg_wr_tim, cfg_ctrl, cfg_strap, cfg_misc, eff_rd_tim, eff_wr_tim;

  always #10 clk = ~clk;

  assign tf_rdata = {8'hE0, 5'b0, io_addr};

  cfgtrap_bank dut (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
    .io_wide(io_wide), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .tf_rdata(tf_rdata), .tf_req(tf_req), .strap_clk(strap_clk), .unlocked(unlocked),
    .cfg_rd_tim(cfg_rd_tim), .cfg_wr_tim(cfg_wr_tim), .cfg_ctrl(cfg_ctrl),
    .cfg_strap(cfg_strap), .cfg_misc(cfg_misc), .tim_override(tim_override),
    .eff_rd_tim(eff_rd_tim), .eff_wr_tim(eff_wr_tim)
  );

  typedef struct {
    logic        chk_rd;
    logic [15:0] rd;
    logic        tf;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   finished = 0;

  function automatic logic [15:0] tfv(input logic [2:0] a);
    return {8'hE0, 5'b0, a};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic wide, input logic [2:0] a,
                     input logic [15:0] d, input logic exp_tf, input logic chk_rd,
                     input logic [15:0] exp_rd, input string tag);
    exp_t e;
    e.chk_rd = chk_rd; e.rd = exp_rd; e.tf = exp_tf; e.tag = tag;
    q.push_back(e);
    @(posedge clk); #2;
    io_valid = 1'b1; io_write = wr; io_wide = wide; io_addr = a; io_wdata = d;
    @(posedge clk); #2;
    io_valid = 1'b0; io_write = 1'b0;
  endtask

  task automatic wr8(input logic [2:0] a, input logic [7:0] d, input logic tf, input string tag);
    acc(1'b1, 1'b0, a, {8'h00, d}, tf, 1'b0, 16'h0, tag);
  endtask

  task automatic rd16(input logic [2:0] a, input logic tf, input logic [15:0] r, input string tag);
    acc(1'b0, 1'b1, a, 16'h0, tf, 1'b1, r, tag);
  endtask

  task automatic rd8(input logic [2:0] a, input logic tf, input logic [15:0] r, input string tag);
    acc(1'b0, 1'b0, a, 16'h0, tf, 1'b1, r, tag);
  endtask

  task automatic open_bank(input string tag);
    rd16(3'd1, 1'b1, tfv(3'd1), {tag, " R3 probe read 1"});
    rd16(3'd1, 1'b1, tfv(3'd1), {tag, " R3 probe read 2"});
    wr8(3'd2, 8'h03, 1'b0, {tag, " R2 key consumed"});
  endtask

  // monitor: pops one expected item per access seen mid-cycle
  always @(negedge clk) begin
    if (rst_n === 1'b1 && io_valid === 1'b1) begin
      if (q.size() == 0) chk("monitor unexpected access", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " tf_req"}, tf_req, e.tf);
        if (e.chk_rd) chk({e.tag, " rdata"}, io_rdata, e.rd);
      end
    end
  end

  initial begin
    #4_000_000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; io_valid = 1'b0; io_write = 1'b0; io_wide = 1'b0;
    io_addr = '0; io_wdata = '0; strap_clk = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 unlocked", unlocked, 0);
    chk("R1 regs", {cfg_rd_tim, cfg_wr_tim, cfg_ctrl, cfg_misc}, 32'h0);
    chk("R1 strap reg", cfg_strap, 0);
    chk("R1 override", tim_override, 0);
    chk("R1 eff strap0", {eff_rd_tim, eff_wr_tim}, 16'h6B6B);
    strap_clk = 1'b1; #1;
    chk("R1 eff strap1", {eff_rd_tim, eff_wr_tim}, 16'h5858);
    strap_clk = 1'b0;

    // R5 bare key
    wr8(3'd2, 8'h03, 1'b1, "R5 bare key forwarded");
    chk("R5 still locked", unlocked, 0);

    // R4 aborts
    rd16(3'd1, 1'b1, tfv(3'd1), "R4 a");
    rd16(3'd1, 1'b1, tfv(3'd1), "R4 b");
    rd8(3'd7, 1'b1, tfv(3'd7), "R4 foreign read");
    wr8(3'd2, 8'h03, 1'b1, "R4 key after abort");
    chk("R4 locked after foreign read", unlocked, 0);
    rd16(3'd1, 1'b1, tfv(3'd1), "R4 c");
    wr8(3'd3, 8'h11, 1'b1, "R4 foreign write");
    rd16(3'd1, 1'b1, tfv(3'd1), "R4 d");
    wr8(3'd2, 8'h03, 1'b1, "R4 key after one read");
    chk("R4 locked after foreign write", unlocked, 0);
    rd16(3'd1, 1'b1, tfv(3'd1), "R4 e");
    rd8(3'd1, 1'b1, tfv(3'd1), "R4 narrow probe");
    rd16(3'd1, 1'b1, tfv(3'd1), "R4 f");
    wr8(3'd2, 8'h03, 1'b1, "R4 key after narrow");
    chk("R4 locked after narrow read", unlocked, 0);
    chk("R8 locked writes ignored", cfg_ctrl, 0);

    // R4 third read keeps it armed, R2 open
    rd16(3'd1, 1'b1, tfv(3'd1), "R4 triple 1");
    open_bank("open1");
    chk("R2 unlocked", unlocked, 1);

    // R6 writes and reads
    wr8(3'd0, 8'h31, 1'b0, "R6 wr rdtim");
    wr8(3'd1, 8'h22, 1'b0, "R6 wr wrtim");
    wr8(3'd6, 8'h10, 1'b0, "R6 wr misc");
    wr8(3'd5, 8'h12, 1'b0, "R6 wr strap");
    acc(1'b1, 1'b1, 3'd3, 16'hAA00, 1'b0, 1'b0, 16'h0, "R6 wide wr ctrl low byte");
    chk("R6 regs", {cfg_rd_tim, cfg_wr_tim, cfg_ctrl, cfg_misc}, 32'h3122_0010);
    chk("R6 strap reg", cfg_strap, 8'h12);
    rd16(3'd0, 1'b0, 16'h0031, "R6 rd rdtim");
    rd8(3'd6, 1'b0, 16'h0010, "R6 rd misc");
    rd16(3'd1, 1'b0, 16'h0022, "R6 rd wrtim");

    // R7 other offsets forwarded
    rd16(3'd7, 1'b1, tfv(3'd7), "R7 rd off7");
    wr8(3'd4, 8'h5A, 1'b1, "R7 wr off4");
    wr8(3'd2, 8'h55, 1'b1, "R7 wr off2 non-key");
    wr8(3'd2, 8'h03, 1'b1, "R7 open key while open");
    chk("R7 still open", unlocked, 1);

    // R10 override
    chk("R10 eff before override", {eff_rd_tim, eff_wr_tim}, 16'h6B6B);
    wr8(3'd3, 8'h85, 1'b0, "R10 ctrl write");
    chk("R10 override set", tim_override, 1);
    chk("R10 eff programmed", {eff_rd_tim, eff_wr_tim}, 16'h3122);

    // R9 strap probe while open
    strap_clk = 1'b1;
    wr8(3'd5, 8'hFF, 1'b0, "R9 arm open");
    rd16(3'd5, 1'b0, 16'h0001, "R9 probe open");
    rd16(3'd5, 1'b0, 16'h00FF, "R9 unarmed read gives reg");

    // R8 relock
    wr8(3'd2, 8'h83, 1'b0, "R8 close key consumed");
    chk("R8 locked", unlocked, 0);
    wr8(3'd0, 8'h77, 1'b1, "R8 locked write forwarded");
    chk("R8 rdtim unchanged", cfg_rd_tim, 8'h31);
    rd16(3'd0, 1'b1, tfv(3'd0), "R8 locked read forwarded");

    // R9 strap probe while locked
    wr8(3'd5, 8'hFF, 1'b1, "R9 arm locked");
    rd16(3'd5, 1'b0, 16'h0001, "R9 probe locked");
    rd16(3'd5, 1'b1, tfv(3'd5), "R9 probe once only");
    strap_clk = 1'b0;
    wr8(3'd5, 8'hFF, 1'b1, "R9 arm again");
    rd16(3'd4, 1'b1, tfv(3'd4), "R9 disarm by other");
    rd16(3'd5, 1'b1, tfv(3'd5), "R9 disarmed");
    wr8(3'd5, 8'hFF, 1'b1, "R9 arm strap0");
    rd16(3'd5, 1'b0, 16'h0000, "R9 probe strap0");

    // R10 override clear
    open_bank("open2");
    strap_clk = 1'b1;
    wr8(3'd3, 8'h00, 1'b0, "R10 ctrl clear");
    chk("R10 override clear", tim_override, 0);
    chk("R10 eff default strap1", {eff_rd_tim, eff_wr_tim}, 16'h5858);

    @(negedge clk);
    chk("scoreboard drained", q.size(), 0);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule